// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block serialises data words onto an idle-high asynchronous line. A one-word holding register sits in front of the frame shifter, so the next word can be written while the current frame is still on the wire. Each frame is a low start bit, then 8 or 9 data bits least significant bit first, then one high stop bit. There is no parity. The timing comes from an oversampling tick input: every bit lasts a fixed number of ticks.

Two empty flags are kept apart. The holding-empty flag asks for the next word and feeds the interrupt request, which is gated by an enable input. The shift-empty flag only says that the line has finished sending everything, and it drives no interrupt. Dropping the transmit enable abandons whatever is in flight and returns the block to its idle state.

Top module: `sertx_dbuf`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1 and `shift_empty` is 1.
- R2: In 8-bit mode (`nine_mode`=0) a frame is bit 0 = start (0), bits 1..8 = `wr_data` LSB first, bit 9 = stop (1). That is 10 bit times. `wr_bit9` is not sent.
- R3: In 9-bit mode (`nine_mode`=1), `wr_bit9` follows the eighth data bit and the stop bit is bit 10 (11 bit times). The mode and the ninth bit are captured at the write strobe.
- R4: Each bit lasts exactly TICKS_PER_BIT `baud_tick` pulses. Without ticks the line does not change.
- R5: A write accepted while the holding register is empty takes effect at the next edge (`hold_empty` goes 0). If the shifter is idle, the word moves to the shifter at the edge after that: `hold_empty` goes back to 1, `shift_empty` goes to 0 and `txd` goes to 0.
- R6: A word written while a frame is in flight stays in the holding register until the stop bit has lasted its full time. At that same edge it loads, with no idle time between frames, and `hold_empty` rises.
- R7: A write strobe while the holding register is full is discarded.
- R8: `shift_empty` returns to 1 only when a stop bit completes and no word is waiting, or when the block is disabled.
- R9: `irq` is 1 exactly when `hold_empty` and `irq_en` are both 1.
- R10: While `tx_en` is 0, the frame in flight is abandoned, the holding register is emptied, `txd` is 1, both flags are 1 and writes are ignored. After `tx_en` returns, nothing is sent until a new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable; 0 aborts and holds idle |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Data word |
| wr_bit9 | input | 1 | Ninth data bit, captured with the write |
| nine_mode | input | 1 | 1 selects 9-bit frames, captured with the write |
| baud_tick | input | 1 | Oversampling tick, TICKS_PER_BIT per bit |
| irq_en | input | 1 | Interrupt enable |
| txd | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding register empty |
| shift_empty | output | 1 | Shifter idle (poll only) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DATA_W=8 and TICKS_PER_BIT=4. It pulses `baud_tick` once every three clocks, so a bit takes 12 clocks and an 11-bit frame fits in about 130 cycles. Because the tick is not present on every clock, the bench can show that only ticks advance the bit timer. The short frames keep back-to-back loads, discarded writes and aborts in the middle of a frame within a few hundred cycles each. The bench samples every bit at the middle of its tick window, counting the ticks itself.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic {SH_IDLE, SH_SEND} sh_state_e;

  // Total bit times of one frame: start + data (+ ninth) + stop.
  function automatic int frame_bits(input logic nine, input int data_w);
    return data_w + 2 + (nine ? 1 : 0);
  endfunction

endpackage

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic baud_tick,
  output logic bit_end
);
  localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt;

  assign bit_end = run && baud_tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || !run) begin
      cnt <= '0;
    end else if (baud_tick) begin
      cnt <= bit_end ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_b9,
  input  logic              wr_nine,
  input  logic              shifter_busy,
  input  logic              frame_done,
  output logic              xfer,
  output logic              hold_empty,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_b9,
  output logic              hold_nine
);
  logic full;
  logic accept;

  assign accept     = enable && wr_stb && !full;
  assign xfer       = enable && full && (!shifter_busy || frame_done);
  assign hold_empty = !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full      <= 1'b0;
      hold_data <= '0;
      hold_b9   <= 1'b0;
      hold_nine <= 1'b0;
    end else if (!enable) begin
      full <= 1'b0;
    end else if (xfer) begin
      full <= 1'b0;
    end else if (accept) begin
      full      <= 1'b1;
      hold_data <= wr_data;
      hold_b9   <= wr_b9;
      hold_nine <= wr_nine;
    end
  end

  // R7: a strobe into a full, non-draining holding register changes nothing
  a_r7_full_write_discarded: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && full && wr_stb && !xfer) |=> (!hold_empty && hold_data == $past(hold_data)));

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_b9,
  input  logic              load_nine,
  input  logic              baud_tick,
  output logic              txd,
  output logic              busy,
  output logic              frame_done
);
  import sertx_pkg::*;

  localparam int FRAME_MAX = DATA_W + 3;
  localparam int IDX_W     = $clog2(FRAME_MAX + 1);

  sh_state_e            state;
  logic [FRAME_MAX-1:0] shreg;
  logic [IDX_W-1:0]     left;
  logic                 bit_end;

  function automatic logic [FRAME_MAX-1:0] build_frame(
    input logic [DATA_W-1:0] d, input logic b9, input logic nine);
    logic [FRAME_MAX-1:0] f;
    f = '1;
    f[0] = 1'b0;
    f[DATA_W:1] = d;
    if (nine) f[DATA_W+1] = b9;
    return f;
  endfunction

  sertx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (load),
    .run       (busy && enable),
    .baud_tick (baud_tick),
    .bit_end   (bit_end)
  );

  assign busy       = (state == SH_SEND);
  assign frame_done = bit_end && (left == IDX_W'(1));
  assign txd        = shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SH_IDLE;
      shreg <= '1;
      left  <= '0;
    end else if (!enable) begin
      state <= SH_IDLE;
      shreg <= '1;
      left  <= '0;
    end else if (load) begin
      state <= SH_SEND;
      shreg <= build_frame(load_data, load_b9, load_nine);
      left  <= IDX_W'(frame_bits(load_nine, DATA_W));
    end else if (bit_end) begin
      shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
      left  <= left - 1'b1;
      if (left == IDX_W'(1)) state <= SH_IDLE;
    end
  end

  // R2: a load puts the start bit on the line at once
  a_r2_start_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd);

  // R4: without a tick, load or abort, the line holds its level
  a_r4_line_steady_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !baud_tick && !load) |=> $stable(txd));

endmodule

// File: rtl/sertx_dbuf.sv
module sertx_dbuf #(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              nine_mode,
  input  logic              baud_tick,
  input  logic              irq_en,
  output logic              txd,
  output logic              hold_empty,
  output logic              shift_empty,
  output logic              irq
);
  logic              xfer;
  logic              busy;
  logic              frame_done;
  logic [DATA_W-1:0] hold_data;
  logic              hold_b9;
  logic              hold_nine;

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (tx_en),
    .wr_stb       (wr_stb),
    .wr_data      (wr_data),
    .wr_b9        (wr_bit9),
    .wr_nine      (nine_mode),
    .shifter_busy (busy),
    .frame_done   (frame_done),
    .xfer         (xfer),
    .hold_empty   (hold_empty),
    .hold_data    (hold_data),
    .hold_b9      (hold_b9),
    .hold_nine    (hold_nine)
  );

  sertx_shifter #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (tx_en),
    .load       (xfer),
    .load_data  (hold_data),
    .load_b9    (hold_b9),
    .load_nine  (hold_nine),
    .baud_tick  (baud_tick),
    .txd        (txd),
    .busy       (busy),
    .frame_done (frame_done)
  );

  assign shift_empty = !busy;
  assign irq         = hold_empty && irq_en;

  // R10: disabled block sits idle with both flags set
  a_r10_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (txd && hold_empty && shift_empty));

  // R6: holding data moves only into an idle shifter or at a frame end
  a_r6_xfer_only_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> (shift_empty || frame_done));

  // R8: shifter becomes empty only after a stop bit or an abort
  a_r8_empty_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_empty) |-> ($past(frame_done) || !$past(tx_en)));

  // R5: an accepted write clears the holding-empty flag at the next edge
  a_r5_write_fills_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && wr_stb && hold_empty) |=> (!hold_empty || !$past(tx_en)));

endmodule

// File: tb/test_sertx_dbuf.sv
`timescale 1ns/1ps
module test_sertx_dbuf;
  localparam int DW       = 8;
  localparam int TPB      = 4;
  localparam int TICK_GAP = 3;
  localparam int NVEC     = 6;

  // {nine_mode, wr_bit9, wr_data}
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'hA5},
    {1'b0, 1'b0, 8'h00},
    {1'b0, 1'b1, 8'hFF},
    {1'b1, 1'b1, 8'h3C},
    {1'b1, 1'b0, 8'h81},
    {1'b0, 1'b0, 8'h5A}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          tx_en = 1'b1;
  logic          wr_stb = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_bit9 = 1'b0;
  logic          nine_mode = 1'b0;
  logic          baud_tick = 1'b0;
  logic          irq_en = 1'b1;
  logic          txd, hold_empty, shift_empty, irq;

  int  n_run = 0;
  int  n_fail = 0;
  bit  tick_on = 1'b1;
  int  tick_ph = 0;

  sertx_dbuf #(.DATA_W(DW), .TICKS_PER_BIT(TPB)) i_sertx_dbuf (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_stb(wr_stb), .wr_data(wr_data),
    .wr_bit9(wr_bit9), .nine_mode(nine_mode), .baud_tick(baud_tick), .irq_en(irq_en),
    .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty), .irq(irq)
  );

  always @(negedge clk) begin
    tick_ph   <= (tick_ph == TICK_GAP - 1) ? 0 : tick_ph + 1;
    baud_tick <= tick_on && (tick_ph == TICK_GAP - 1);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_frame(input logic [7:0] d, input logic b9,
                                            input logic nine);
    logic [10:0] f;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[i+1] = d[i];
    if (nine) f[9] = b9;
    return f;
  endfunction

  task automatic wr(input logic [7:0] d, input logic b9, input logic nine);
    @(negedge clk);
    wr_stb = 1'b1; wr_data = d; wr_bit9 = b9; nine_mode = nine;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic capture(input int nb, output logic [10:0] got);
    int tc = 0, k = 0, guard = 0;
    bit hit;
    got = '1;
    while (txd !== 1'b0 && guard < 3000) begin
      @(negedge clk); guard++;
    end
    guard = 0;
    while (k < nb && guard < 5000) begin
      @(posedge clk);
      hit = 1'b0;
      if (baud_tick) begin
        tc++;
        hit = (tc == k * TPB + TPB / 2);
      end
      @(negedge clk);
      if (hit) begin got[k] = txd; k++; end
      guard++;
    end
  endtask

  task automatic wait_shift_empty();
    int g = 0;
    while (shift_empty !== 1'b1 && g < 3000) begin @(negedge clk); g++; end
  endtask

  task automatic wait_hold_empty();
    int g = 0;
    while (hold_empty !== 1'b1 && g < 3000) begin @(negedge clk); g++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [10:0] g1, g2;
    int cnt, bad;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", txd, 1, "txd after reset");
    chk("R1", hold_empty, 1, "hold_empty after reset");
    chk("R1", shift_empty, 1, "shift_empty after reset");
    chk("R9", irq, 1, "irq with enable and empty holding");
    irq_en = 1'b0; #1;
    chk("R9", irq, 0, "irq masked");
    irq_en = 1'b1;

    // table-driven frames (R2 R3 R5 R8)
    for (int i = 0; i < NVEC; i++) begin
      logic [9:0] v;
      int nb;
      v  = VEC[i];
      nb = v[9] ? 11 : 10;
      wr(v[7:0], v[8], v[9]);
      chk("R5", hold_empty, 0, "hold_empty after write");
      chk("R9", irq, 0, "irq while holding full");
      @(negedge clk);
      chk("R5", {hold_empty, shift_empty, txd}, 3'b100, "state after transfer");
      capture(nb, g1);
      chk(v[9] ? "R3" : "R2", g1, exp_frame(v[7:0], v[8], v[9]), "frame bits");
      wait_shift_empty();
      chk("R8", {shift_empty, txd}, 2'b11, "idle after frame");
    end

    // back-to-back (R6)
    wr(8'hA5, 1'b0, 1'b0);
    @(negedge clk);
    fork
      capture(10, g1);
      begin
        repeat (20) @(negedge clk);
        wr(8'h3C, 1'b1, 1'b1);
        chk("R6", hold_empty, 0, "second word held");
        repeat (30) @(negedge clk);
        chk("R6", {hold_empty, shift_empty}, 2'b00, "still waiting for stop");
      end
    join
    wait_hold_empty();
    chk("R6", {txd, shift_empty}, 2'b00, "second start with no gap");
    capture(11, g2);
    chk("R6", g1, exp_frame(8'hA5, 1'b0, 1'b0), "first frame");
    chk("R6", g2, exp_frame(8'h3C, 1'b1, 1'b1), "second frame");
    wait_shift_empty();

    // write into full holding register (R7)
    wr(8'h11, 1'b0, 1'b0);
    @(negedge clk);
    fork
      capture(10, g1);
      begin
        repeat (10) @(negedge clk);
        wr(8'h22, 1'b0, 1'b0);
        wr(8'h33, 1'b1, 1'b1);
        chk("R7", hold_empty, 0, "holding still full");
      end
    join
    wait_hold_empty();
    capture(10, g2);
    chk("R7", g2, exp_frame(8'h22, 1'b0, 1'b0), "held word kept");
    wait_shift_empty();
    bad = 0;
    repeat (60) begin @(negedge clk); if (txd !== 1'b1 || shift_empty !== 1'b1) bad++; end
    chk("R7", bad, 0, "discarded word never sent");

    // tick gating and bit duration (R4)
    tick_on = 1'b0;
    wr(8'h01, 1'b0, 1'b0);
    @(negedge clk);
    repeat (60) @(negedge clk);
    chk("R4", {txd, shift_empty}, 2'b00, "no ticks keeps start bit");
    tick_on = 1'b1;
    cnt = 0;
    for (int g = 0; g < 500 && txd === 1'b0; g++) begin
      @(posedge clk); if (baud_tick) cnt++;
      @(negedge clk);
    end
    chk("R4", cnt, TPB, "ticks per start bit");
    wait_shift_empty();

    // abort (R10)
    wr(8'h00, 1'b0, 1'b0);
    @(negedge clk);
    repeat (30) @(negedge clk);
    wr(8'h55, 1'b0, 1'b0);
    tx_en = 1'b0;
    @(negedge clk);
    chk("R10", {txd, hold_empty, shift_empty}, 3'b111, "abort to idle");
    wr(8'hAA, 1'b0, 1'b0);
    chk("R10", hold_empty, 1, "write ignored while disabled");
    bad = 0;
    repeat (40) begin @(negedge clk); if (txd !== 1'b1) bad++; end
    chk("R10", bad, 0, "line high while disabled");
    tx_en = 1'b1;
    bad = 0;
    repeat (40) begin @(negedge clk); if (txd !== 1'b1 || shift_empty !== 1'b1) bad++; end
    chk("R10", bad, 0, "nothing sent after re-enable");
    wr(8'hC3, 1'b0, 1'b0);
    @(negedge clk);
    capture(10, g1);
    chk("R10", g1, exp_frame(8'hC3, 1'b0, 1'b0), "frame after re-enable");
    wait_shift_empty();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule